// File: doc/BRIEF.md
# Paged edge-interrupt GPIO controller

This block is a 48-line general-purpose I/O controller seen from an 8-bit synchronous register bus with a 4-bit address. The lines form six 8-bit ports. Each port has an output latch and a readback of the pin levels. A latch bit of 1 drives its line. A latch bit of 0 leaves the line undriven, so software makes a line an input by writing 0 to its latch bit.

The lower three ports (lines 0 to 23) also watch for edges. Each of these lines has an enable bit and a polarity bit, which picks either rising or falling edges. When an enabled line sees an edge of the chosen direction, its pending bit is latched. The three per-port interrupt registers share one address range. A page register decides whether that range shows the enable bits, the polarity bits or the pending bits. A summary register has one flag per port that holds a pending edge, and a single interrupt output is raised while any line is pending.

Software acknowledges a line by clearing its enable bit and then setting it again. Clearing the enable bit clears the pending bit. An edge detected in the same cycle as that clearing write is kept and stays pending.

Top module: `edge_irq_gpio`

## Requirements
- R1: A write to offset k (0 to 5) loads port k's output latch. `pin_drive[8k+b]` equals latch bit b, where 1 drives the line and 0 leaves it undriven.
- R2: A read of offset k (0 to 5) returns port k's pin levels after a two-flop synchroniser. A pin change appears in the data read after the second rising clock edge.
- R3: Offset 7 holds a readable 8-bit page register. Bits [7:6] select what offsets 8 to 10 show: 2'b10 enable, 2'b01 polarity, 2'b11 pending. With 2'b00, offsets 8 to 10 read 0 and ignore writes.
- R4: On the enable page, offsets 8 to 10 read and write the per-line enable bits of ports 0 to 2. Line n is bit n%8 of offset 8+n/8.
- R5: On the polarity page, offsets 8 to 10 read and write the polarity bits. A bit of 1 selects rising edges and a bit of 0 selects falling edges.
- R6: A pending bit sets only when its line is enabled and an edge of the selected polarity is seen. Lines 24 to 47 never set a pending bit.
- R7: On the pending page, offsets 8 to 10 return the pending bits of ports 0 to 2. Writes on this page change nothing.
- R8: A read of offset 6 returns in bit p (0 to 2) the OR of port p's pending bits. Bits [7:3] read 0.
- R9: A write on the enable page that changes an enable bit from 1 to 0 clears that line's pending bit. An edge detected in the same cycle keeps the bit pending.
- R10: `irq` is 1 exactly when at least one pending bit is set.
- R11: Reset sets all latches, enable, polarity and pending bits and the page register to 0, so `irq` and `pin_drive` are 0.
- R12: Reads of offsets 11 to 15, and of any offset while `bus_sel` is 0, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of a read strobe |
| pin_in | input | 48 | Pin levels, asynchronous |
| pin_drive | output | 48 | Output latches; 1 drives the line |
| irq | output | 1 | Interrupt request, OR of all pending bits |

## Verification
Some properties are checked on every cycle. A pending bit never rises unless its enable bit was set one cycle earlier, and the interrupt never rises without an enabled line. A latch write reaches `pin_drive` on the next cycle, and reset clears the interrupt, the latches and the page. Reads return 0 in the summary's upper bits, at offsets 11 to 15 and on the empty page.

Other behaviour depends on the edge history of the pins, so only the bench scenarios can show it. This covers edge direction against polarity, the two-edge latency of pin readback, the fact that writes on the pending page are ignored, and acknowledge by toggling the enable bit. It also covers an edge that lands in the same cycle as the disabling write and must survive it.

// File: rtl/eig_pkg.sv
package eig_pkg;

    // Meaning of page register bits [7:6].
    typedef enum logic [1:0] {
        PG_OFF = 2'b00,
        PG_POL = 2'b01,
        PG_EN  = 2'b10,
        PG_ID  = 2'b11
    } page_e;

    // Bus access captured from the port pins.
    typedef struct packed {
        logic       sel;
        logic       we;
        logic [3:0] addr;
    } bus_ctl_t;

    function automatic page_e page_decode(input logic [7:0] page_val);
        return page_e'(page_val[7:6]);
    endfunction

endpackage

// File: rtl/eig_sync.sv
module eig_sync #(
    parameter int W      = 48,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/eig_irq_port.sv
module eig_irq_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,     // synchronised pin levels
    input  logic         wr_en,   // write to this port's enable register
    input  logic         wr_pol,  // write to this port's polarity register
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en,
    output logic [W-1:0] pol,
    output logic [W-1:0] pend
);
    logic [W-1:0] prev_q;
    logic [W-1:0] rise, fall, hit, clr;

    always_comb begin
        rise = lvl & ~prev_q;
        fall = ~lvl & prev_q;
        hit  = en & ((pol & rise) | (~pol & fall));
        // Only a 1 -> 0 transition of an enable bit acknowledges the line.
        clr  = wr_en ? (en & ~wdata) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            en     <= '0;
            pol    <= '0;
            pend   <= '0;
        end else begin
            prev_q <= lvl;
            if (wr_en)  en  <= wdata;
            if (wr_pol) pol <= wdata;
            // A fresh edge wins over a clear in the same cycle.
            pend   <= hit | (pend & ~clr);
        end
    end
endmodule

// File: rtl/edge_irq_gpio.sv
module edge_irq_gpio
    import eig_pkg::*;
#(
    parameter int PORT_W      = 8,
    parameter int N_PORTS     = 6,
    parameter int N_IRQ_PORTS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_sel,
    input  logic                        bus_we,
    input  logic [3:0]                  bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [PORT_W*N_PORTS-1:0]   pin_in,
    output logic [PORT_W*N_PORTS-1:0]   pin_drive,
    output logic                        irq
);
    localparam int N_LINES     = PORT_W * N_PORTS;
    localparam int OFS_SUMMARY = N_PORTS;
    localparam int OFS_PAGE    = N_PORTS + 1;
    localparam int OFS_IRQ0    = N_PORTS + 2;

    bus_ctl_t ctl;
    assign ctl = '{sel: bus_sel, we: bus_we, addr: bus_addr};

    logic        wr_any;
    logic [7:0]  page_q;
    page_e       pg;

    assign wr_any = ctl.sel & ctl.we;
    assign pg     = page_decode(page_q);

    // Page register.
    always_ff @(posedge clk) begin
        if (rst)                                          page_q <= '0;
        else if (wr_any && int'(ctl.addr) == OFS_PAGE)    page_q <= bus_wdata;
    end

    // Output latches, one per port.
    generate
        for (genvar p = 0; p < N_PORTS; p++) begin : g_latch
            always_ff @(posedge clk) begin
                if (rst)
                    pin_drive[p*PORT_W +: PORT_W] <= '0;
                else if (wr_any && int'(ctl.addr) == p)
                    pin_drive[p*PORT_W +: PORT_W] <= bus_wdata;
            end
        end
    endgenerate

    // Input synchronisers.
    logic [N_LINES-1:0] pin_sync;

    eig_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    // Edge-detecting ports.
    logic [N_IRQ_PORTS-1:0][PORT_W-1:0] en_all, pol_all, pend_all;
    logic [N_IRQ_PORTS-1:0]             summary;

    generate
        for (genvar i = 0; i < N_IRQ_PORTS; i++) begin : g_irq
            logic hit_addr;
            assign hit_addr = wr_any && int'(ctl.addr) == OFS_IRQ0 + i;

            eig_irq_port #(.W(PORT_W)) u_port (
                .clk    (clk),
                .rst    (rst),
                .lvl    (pin_sync[i*PORT_W +: PORT_W]),
                .wr_en  (hit_addr && pg == PG_EN),
                .wr_pol (hit_addr && pg == PG_POL),
                .wdata  (bus_wdata),
                .en     (en_all[i]),
                .pol    (pol_all[i]),
                .pend   (pend_all[i])
            );

            assign summary[i] = |pend_all[i];
        end
    endgenerate

    assign irq = |summary;

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (ctl.sel && !ctl.we) begin
            for (int k = 0; k < N_PORTS; k++)
                if (int'(ctl.addr) == k) bus_rdata = pin_sync[k*PORT_W +: PORT_W];
            if (int'(ctl.addr) == OFS_SUMMARY)
                bus_rdata = {{(PORT_W-N_IRQ_PORTS){1'b0}}, summary};
            if (int'(ctl.addr) == OFS_PAGE)
                bus_rdata = page_q;
            for (int j = 0; j < N_IRQ_PORTS; j++) begin
                if (int'(ctl.addr) == OFS_IRQ0 + j) begin
                    case (pg)
                        PG_EN:   bus_rdata = en_all[j];
                        PG_POL:  bus_rdata = pol_all[j];
                        PG_ID:   bus_rdata = pend_all[j];
                        default: bus_rdata = '0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/eig_chk.sv
module eig_chk #(
    parameter int PORT_W      = 8,
    parameter int N_PORTS     = 6,
    parameter int N_IRQ_PORTS = 3
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              bus_sel,
    input logic                              bus_we,
    input logic [3:0]                        bus_addr,
    input logic [PORT_W-1:0]                 bus_wdata,
    input logic [PORT_W-1:0]                 bus_rdata,
    input logic [PORT_W*N_PORTS-1:0]         pin_drive,
    input logic                              irq,
    input logic [N_IRQ_PORTS*PORT_W-1:0]     en_all,
    input logic [N_IRQ_PORTS*PORT_W-1:0]     pend_all,
    input logic [7:0]                        page_q
);
    localparam int OFS_SUMMARY = N_PORTS;
    localparam int OFS_IRQ0    = N_PORTS + 2;
    localparam int OFS_LAST    = OFS_IRQ0 + N_IRQ_PORTS - 1;

    logic rd;
    assign rd = bus_sel && !bus_we;

    // R1
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && int'(bus_addr) < N_PORTS) |=>
        pin_drive[int'($past(bus_addr))*PORT_W +: PORT_W] == $past(bus_wdata));

    // R3
    page_off_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && page_q[7:6] == 2'b00 && int'(bus_addr) >= OFS_IRQ0 &&
         int'(bus_addr) <= OFS_LAST) |-> bus_rdata == '0);

    // R6
    pend_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        ((pend_all & ~$past(pend_all)) & ~$past(en_all)) == '0);

    // R8
    summary_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && int'(bus_addr) == OFS_SUMMARY) |->
        bus_rdata[PORT_W-1:N_IRQ_PORTS] == '0);

    // R10
    irq_rise_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(en_all) != '0);

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!irq && pin_drive == '0 && page_q == '0));

    // R12
    high_ofs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ((rd && int'(bus_addr) > OFS_LAST) || !bus_sel) |-> bus_rdata == '0);
endmodule

bind edge_irq_gpio eig_chk #(
    .PORT_W(PORT_W), .N_PORTS(N_PORTS), .N_IRQ_PORTS(N_IRQ_PORTS)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_drive (pin_drive),
    .irq       (irq),
    .en_all    (en_all),
    .pend_all  (pend_all),
    .page_q    (page_q)
);

// File: tb/edge_irq_gpio_tb_top.sv
module edge_irq_gpio_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pins = '0;
    logic [47:0] pin_drive;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model.
    logic [47:0] m_latch = '0;
    logic [23:0] m_en = '0, m_pol = '0, m_pend = '0;
    logic [7:0]  m_page = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_gpio dut_i (
        .clk (clk), .rst (rst), .bus_sel (bus_sel), .bus_we (bus_we),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pins), .pin_drive (pin_drive), .irq (irq)
    );

    function automatic logic [7:0] exp_summary();
        return {5'b0, |m_pend[23:16], |m_pend[15:8], |m_pend[7:0]};
    endfunction

    function automatic logic [7:0] exp_paged(input int p);
        case (m_page[7:6])
            2'b10:   return m_en[p*8 +: 8];
            2'b01:   return m_pol[p*8 +: 8];
            2'b11:   return m_pend[p*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic w_latch(input int p, input logic [7:0] d);
        bus_write(4'(p), d);
        m_latch[p*8 +: 8] = d;
    endtask

    task automatic w_page(input logic [7:0] d);
        bus_write(4'd7, d);
        m_page = d;
    endtask

    task automatic w_irqreg(input int p, input logic [7:0] d);
        bus_write(4'(8 + p), d);
        case (m_page[7:6])
            2'b10: begin
                m_pend[p*8 +: 8] = m_pend[p*8 +: 8] & ~(m_en[p*8 +: 8] & ~d);
                m_en[p*8 +: 8]   = d;
            end
            2'b01:   m_pol[p*8 +: 8] = d;
            default: ;
        endcase
    endtask

    task automatic set_pin(input int n, input logic v);
        logic old;
        @(negedge clk);
        old = pins[n];
        pins[n] = v;
        if (n < 24 && old != v && m_en[n] && v == m_pol[n]) m_pend[n] = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] d;
        for (int p = 0; p < 6; p++) begin
            bus_read(4'(p), d);
            chk({tag, " R2 port read"}, 48'(d), 48'(pins[p*8 +: 8]));
        end
        bus_read(4'd6, d);
        chk({tag, " R8 summary"}, 48'(d), 48'(exp_summary()));
        bus_read(4'd7, d);
        chk({tag, " R3 page readback"}, 48'(d), 48'(m_page));
        for (int p = 0; p < 3; p++) begin
            bus_read(4'(8 + p), d);
            chk({tag, " R4/R5 paged read"}, 48'(d), 48'(exp_paged(p)));
        end
        w_page(8'hC0);
        for (int p = 0; p < 3; p++) begin
            bus_read(4'(8 + p), d);
            chk({tag, " R7 pending read"}, 48'(d), 48'(m_pend[p*8 +: 8]));
        end
        chk({tag, " R10 irq"}, 48'(irq), 48'(|m_pend));
        chk({tag, " R1 pin_drive"}, pin_drive, m_latch);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state.
        @(negedge clk);
        chk("R11 irq after reset", 48'(irq), 48'd0);
        chk("R11 pin_drive after reset", pin_drive, 48'd0);
        bus_read(4'd7, d);
        chk("R11 page after reset", 48'(d), 48'd0);
        // R3: empty page reads 0 and ignores writes.
        bus_write(4'd8, 8'hFF);
        bus_read(4'd8, d);
        chk("R3 empty page read", 48'(d), 48'd0);
        w_page(8'h80);
        bus_read(4'd8, d);
        chk("R3 empty-page write ignored", 48'(d), 48'd0);

        // R12: high offsets and idle bus read 0.
        for (int a = 11; a < 16; a++) begin
            bus_read(4'(a), d);
            chk("R12 high offset", 48'(d), 48'd0);
        end

        // R1: latch write.
        w_latch(2, 8'hA5);
        w_latch(5, 8'h3C);
        chk("R1 latch drive", pin_drive, m_latch);

        // R2: two-edge synchroniser latency on line 40.
        @(negedge clk);
        pins[40] = 1'b1;
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 4'd5;
        #1 chk("R2 one edge after change", 48'(bus_rdata[0]), 48'd0);
        @(negedge clk);
        #1 chk("R2 two edges after change", 48'(bus_rdata[0]), 48'd1);
        bus_sel = 1'b0;

        // R5: polarity; R4: enable.
        w_page(8'h40);
        w_irqreg(0, 8'h0F);
        w_page(8'h80);
        w_irqreg(0, 8'hFF);
        set_pin(0, 1'b1);           // rising on rising line: pending
        set_pin(4, 1'b1);           // rising on falling line: none
        check_all("R5 polarity a");
        set_pin(4, 1'b0);           // falling on falling line: pending
        check_all("R5 polarity b");

        // R7: writes on pending page ignored.
        bus_write(4'd8, 8'h00);
        w_page(8'h80);
        check_all("R7 id write ignored");

        // R9: acknowledge by toggling enable.
        w_page(8'h80);
        w_irqreg(0, 8'hEE);
        w_irqreg(0, 8'hFF);
        check_all("R9 ack");

        // R6: upper ports never pend, even if enable writes are attempted.
        w_page(8'h80);
        bus_write(4'd11, 8'hFF);
        set_pin(30, 1'b1);
        set_pin(44, 1'b1);
        set_pin(44, 1'b0);
        chk("R6 upper ports no irq", 48'(irq), 48'd0);
        check_all("R6 upper ports");

        // R9: edge in same cycle as disabling write survives.
        w_page(8'h40);
        w_irqreg(0, 8'h2F);
        w_page(8'h80);
        set_pin(5, 1'b0);
        @(negedge clk);
        pins[5] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'd8;
        bus_wdata = m_en[7:0] & ~8'h20;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        m_en[5] = 1'b0;
        m_pend[5] = 1'b1;
        check_all("R9 same-cycle edge kept");

        // Random mix.
        for (int it = 0; it < 400; it++) begin
            case ($urandom_range(0, 4))
                0, 1: begin
                    int n;
                    n = $urandom_range(0, 47);
                    set_pin(n, ~pins[n]);
                end
                2: begin
                    w_page(8'h80);
                    w_irqreg($urandom_range(0, 2), 8'($urandom));
                end
                3: begin
                    w_page(8'h40);
                    w_irqreg($urandom_range(0, 2), 8'($urandom));
                end
                default: w_latch($urandom_range(0, 5), 8'($urandom));
            endcase
            if (it % 20 == 19) check_all("random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule